// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block drives the control points of a multicycle datapath from a small microprogram instead of from hand-written state logic. A micro-program counter selects one line of a control-store ROM. Each line carries the control-point values for the current cycle in horizontal form, with one output bit per control line and a two-bit ALU operation field as the single encoded field. Each line also carries a two-bit sequencing code that selects the next micro-program counter.

Only three next-address sources exist. The counter can step to the following line or return to line zero, which is the instruction-fetch step. It can also jump to the address that a second ROM gives for the opcode currently in the instruction register. Both ROMs are built from constants at elaboration time. The datapath samples the outputs each cycle. It supplies the opcode and gets the control bits back.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low the micro-program counter is held at 0, and the outputs show the fetch word: `pc_wr`, `ir_wr` and `mem_rd` are 1 and every other output is 0. Reset is asynchronous.
- R2: The counter advances on the rising clock edge and the outputs follow the current line combinationally. After the fetch word, the next cycle shows the decode word: `ext_sign`=1, `alu_imm`=1, `alu_op`=00, and all else 0.
- R3: The sequencing code is 00 for the next line, 01 for the dispatch ROM and 10 for line zero. The decode line uses 01, so the line after decode depends on the opcode: 0 is register-register, 13 is or-immediate, 35 is load, 43 is store, 4 is branch-if-equal and 63 is no-op. The `alu_op` codes are 00 add, 01 subtract, 10 or, and 11 taken from the function field.
- R4: Opcode 0 produces an execute word (`alu_op`=11) followed by a write-back word (`alu_op`=11, `reg_dst_rd`=1, `reg_wr`=1). Fetch follows.
- R5: Opcode 13 produces a word with `alu_imm`=1, `alu_op`=10 and `ext_sign`=0, then the same word with `reg_wr`=1. Fetch follows.
- R6: Opcode 35 produces three words in turn: an address word (`ext_sign`, `alu_imm`), the same word with `mem_rd`, and then `reg_wr` with `mem_to_reg`. Fetch follows.
- R7: Opcode 43 produces an address word (`ext_sign`, `alu_imm`) and then the same word with `mem_wr`. Fetch follows.
- R8: Opcode 4 produces one word with `pc_wr_cond`=1, `pc_src`=1 and `alu_op`=01. Fetch follows.
- R9: Any opcode not listed in R3 produces one all-zero word, so no write enable is set. Fetch follows.
- R10: Sequencing code 11 acts as a return to line zero. The opcode-63 line carries code 11 with all-zero controls, and fetch follows it.
- R11: The opcode input is used only in the decode cycle. Its value in any other cycle has no effect on the outputs.
- R12: Pulling `rst_n` low in the middle of a sequence shows the fetch word at once. After release, the sequence restarts with fetch and then decode.
- R13: `mem_rd` and `mem_wr` are never 1 together, and `pc_wr` and `pc_wr_cond` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OP_W (6) | Opcode field from the instruction register |
| pc_wr | output | 1 | Write the program counter unconditionally |
| pc_wr_cond | output | 1 | Write the program counter if the comparison is equal |
| pc_src | output | 1 | 0 selects the incremented PC, 1 selects the branch target |
| ir_wr | output | 1 | Load the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ext_sign | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| alu_imm | output | 1 | ALU second operand: 1 immediate, 0 register |
| alu_op | output | 2 | ALU operation code (see R3) |
| reg_dst_rd | output | 1 | Destination register: 1 rd field, 0 rt field |
| reg_wr | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Write-back source: 1 memory, 0 ALU |

## Verification
The bench sweeps all 64 opcodes and checks the whole control sequence of each one cycle by cycle, including the fetch that follows. A wrong dispatch entry would therefore show up as a foreign word or a sequence of the wrong length. An unlisted opcode or the no-op must give exactly one quiet cycle. If code 11 were treated as a sequential step, a design would add a stray extra cycle before fetch. During every cycle except decode the bench drives an unrelated opcode, so a design that dispatches late or reads the opcode combinationally would show the wrong words. A reset applied mid-load must show fetch at once, so a design that only clears the counter on a clock edge would keep showing the load word.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        SQ_NEXT = 2'b00,
        SQ_DISP = 2'b01,
        SQ_ZERO = 2'b10,
        SQ_RSVD = 2'b11
    } seq_e;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_OR    = 2'b10,
        ALU_FUNCT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic    pc_wr;
        logic    pc_wr_cond;
        logic    pc_src;
        logic    ir_wr;
        logic    mem_rd;
        logic    mem_wr;
        logic    ext_sign;
        logic    alu_imm;
        alu_op_e alu_op;
        logic    reg_dst_rd;
        logic    reg_wr;
        logic    mem_to_reg;
    } ctl_t;

    typedef struct packed {
        seq_e seq;
        ctl_t ctl;
    } uword_t;

    // opcode values
    localparam int OPC_RTYPE = 0;
    localparam int OPC_BEQ   = 4;
    localparam int OPC_ORI   = 13;
    localparam int OPC_LOAD  = 35;
    localparam int OPC_STORE = 43;
    localparam int OPC_NOP   = 63;

    // microprogram line addresses
    localparam int UA_FETCH   = 0;
    localparam int UA_DECODE  = 1;
    localparam int UA_R_EXE   = 2;
    localparam int UA_R_WB    = 3;
    localparam int UA_I_EXE   = 4;
    localparam int UA_I_WB    = 5;
    localparam int UA_L_ADDR  = 6;
    localparam int UA_L_READ  = 7;
    localparam int UA_L_WB    = 8;
    localparam int UA_S_ADDR  = 9;
    localparam int UA_S_WRITE = 10;
    localparam int UA_BRANCH  = 11;
    localparam int UA_ILLEGAL = 12;
    localparam int UA_NOP     = 13;

    function automatic uword_t ucode_line(int addr);
        uword_t w;
        w = '0;
        w.seq = SQ_ZERO;
        case (addr)
            UA_FETCH: begin
                w.seq        = SQ_NEXT;
                w.ctl.pc_wr  = 1'b1;
                w.ctl.ir_wr  = 1'b1;
                w.ctl.mem_rd = 1'b1;
            end
            UA_DECODE: begin
                w.seq          = SQ_DISP;
                w.ctl.ext_sign = 1'b1;
                w.ctl.alu_imm  = 1'b1;
            end
            UA_R_EXE: begin
                w.seq        = SQ_NEXT;
                w.ctl.alu_op = ALU_FUNCT;
            end
            UA_R_WB: begin
                w.ctl.alu_op     = ALU_FUNCT;
                w.ctl.reg_dst_rd = 1'b1;
                w.ctl.reg_wr     = 1'b1;
            end
            UA_I_EXE: begin
                w.seq         = SQ_NEXT;
                w.ctl.alu_imm = 1'b1;
                w.ctl.alu_op  = ALU_OR;
            end
            UA_I_WB: begin
                w.ctl.alu_imm = 1'b1;
                w.ctl.alu_op  = ALU_OR;
                w.ctl.reg_wr  = 1'b1;
            end
            UA_L_ADDR, UA_S_ADDR: begin
                w.seq          = SQ_NEXT;
                w.ctl.ext_sign = 1'b1;
                w.ctl.alu_imm  = 1'b1;
            end
            UA_L_READ: begin
                w.seq          = SQ_NEXT;
                w.ctl.mem_rd   = 1'b1;
                w.ctl.ext_sign = 1'b1;
                w.ctl.alu_imm  = 1'b1;
            end
            UA_L_WB: begin
                w.ctl.reg_wr     = 1'b1;
                w.ctl.mem_to_reg = 1'b1;
            end
            UA_S_WRITE: begin
                w.ctl.mem_wr   = 1'b1;
                w.ctl.ext_sign = 1'b1;
                w.ctl.alu_imm  = 1'b1;
            end
            UA_BRANCH: begin
                w.ctl.pc_wr_cond = 1'b1;
                w.ctl.pc_src     = 1'b1;
                w.ctl.alu_op     = ALU_SUB;
            end
            UA_NOP: begin
                w.seq = SQ_RSVD;
            end
            default: begin
                w.seq = SQ_ZERO;
            end
        endcase
        return w;
    endfunction

    function automatic int dispatch_target(int op);
        case (op)
            OPC_RTYPE: return UA_R_EXE;
            OPC_ORI:   return UA_I_EXE;
            OPC_LOAD:  return UA_L_ADDR;
            OPC_STORE: return UA_S_ADDR;
            OPC_BEQ:   return UA_BRANCH;
            OPC_NOP:   return UA_NOP;
            default:   return UA_ILLEGAL;
        endcase
    endfunction

endpackage

// File: rtl/useq_cstore.sv
module useq_cstore
    import useq_pkg::*;
#(
    parameter int UPC_W = 4
) (
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);
    localparam int DEPTH = 1 << UPC_W;

    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_line
        assign rom[i] = ucode_line(i);
    end

    assign word = rom[addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OP_W  = 6,
    parameter int UPC_W = 4
) (
    input  logic [OP_W-1:0]  opcode,
    output logic [UPC_W-1:0] target
);
    localparam int ENTRIES = 1 << OP_W;

    logic [UPC_W-1:0] tab [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign tab[i] = UPC_W'(dispatch_target(i));
    end

    assign target = tab[opcode];
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int UPC_W = 4
) (
    input  logic [UPC_W-1:0] upc,
    input  seq_e             seq,
    input  logic [UPC_W-1:0] disp_addr,
    output logic [UPC_W-1:0] upc_nx
);
    always_comb begin
        unique case (seq)
            SQ_NEXT: upc_nx = upc + 1'b1;
            SQ_DISP: upc_nx = disp_addr;
            SQ_ZERO: upc_nx = '0;
            SQ_RSVD: upc_nx = '0;
            default: upc_nx = '0;
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int OP_W  = 6,
    parameter int UPC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            pc_src,
    output logic            ir_wr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ext_sign,
    output logic            alu_imm,
    output logic [1:0]      alu_op,
    output logic            reg_dst_rd,
    output logic            reg_wr,
    output logic            mem_to_reg
);
    typedef struct packed {
        logic [UPC_W-1:0] upc;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [UPC_W-1:0] upc_cur;
    logic [UPC_W-1:0] disp_addr;
    logic [UPC_W-1:0] upc_nx;
    uword_t           word;

    assign upc_cur = st_q.upc;

    useq_cstore #(.UPC_W(UPC_W)) u_cstore (
        .addr (upc_cur),
        .word (word)
    );

    useq_dispatch #(.OP_W(OP_W), .UPC_W(UPC_W)) u_dispatch (
        .opcode (opcode),
        .target (disp_addr)
    );

    useq_next #(.UPC_W(UPC_W)) u_next (
        .upc       (upc_cur),
        .seq       (word.seq),
        .disp_addr (disp_addr),
        .upc_nx    (upc_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = upc_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_wr      = word.ctl.pc_wr;
    assign pc_wr_cond = word.ctl.pc_wr_cond;
    assign pc_src     = word.ctl.pc_src;
    assign ir_wr      = word.ctl.ir_wr;
    assign mem_rd     = word.ctl.mem_rd;
    assign mem_wr     = word.ctl.mem_wr;
    assign ext_sign   = word.ctl.ext_sign;
    assign alu_imm    = word.ctl.alu_imm;
    assign alu_op     = word.ctl.alu_op;
    assign reg_dst_rd = word.ctl.reg_dst_rd;
    assign reg_wr     = word.ctl.reg_wr;
    assign mem_to_reg = word.ctl.mem_to_reg;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
    import useq_pkg::*;
#(
    parameter int OP_W  = 6,
    parameter int UPC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  opcode,
    input logic [UPC_W-1:0] upc,
    input logic             pc_wr,
    input logic             pc_wr_cond,
    input logic             pc_src,
    input logic             ir_wr,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             reg_wr
);
    logic in_decode;
    logic op_known;

    assign in_decode = (upc == UPC_W'(UA_DECODE));
    assign op_known  = (int'(opcode) == OPC_RTYPE) || (int'(opcode) == OPC_ORI) ||
                       (int'(opcode) == OPC_LOAD)  || (int'(opcode) == OPC_STORE) ||
                       (int'(opcode) == OPC_BEQ)   || (int'(opcode) == OPC_NOP);

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> in_decode); // R2

    AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (ir_wr && upc == '0)); // R4

    AST_STORE_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_wr); // R7

    AST_BRANCH_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && int'(opcode) == OPC_BEQ) |=> (pc_wr_cond && pc_src)); // R8

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && !op_known) |=> (!pc_wr && !pc_wr_cond && !ir_wr && !mem_rd && !mem_wr && !reg_wr)); // R9

    AST_RSVD_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && int'(opcode) == OPC_NOP) |=> ##1 ir_wr); // R10

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R13

    AST_PC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_wr && pc_wr_cond)); // R13
endmodule

bind useq_ctrl useq_checker #(.OP_W(OP_W), .UPC_W(UPC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .upc        (upc_cur),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_src     (pc_src),
    .ir_wr      (ir_wr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .reg_wr     (reg_wr)
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OP_W = 6;

    // field order: pc_wr pc_wr_cond pc_src ir_wr mem_rd mem_wr ext_sign alu_imm alu_op reg_dst_rd reg_wr mem_to_reg
    localparam logic [12:0] W_FETCH  = 13'b1_0_0_1_1_0_0_0_00_0_0_0;
    localparam logic [12:0] W_DECODE = 13'b0_0_0_0_0_0_1_1_00_0_0_0;
    localparam logic [12:0] W_REXE   = 13'b0_0_0_0_0_0_0_0_11_0_0_0;
    localparam logic [12:0] W_RWB    = 13'b0_0_0_0_0_0_0_0_11_1_1_0;
    localparam logic [12:0] W_OEXE   = 13'b0_0_0_0_0_0_0_1_10_0_0_0;
    localparam logic [12:0] W_OWB    = 13'b0_0_0_0_0_0_0_1_10_0_1_0;
    localparam logic [12:0] W_ADDR   = 13'b0_0_0_0_0_0_1_1_00_0_0_0;
    localparam logic [12:0] W_LRD    = 13'b0_0_0_0_1_0_1_1_00_0_0_0;
    localparam logic [12:0] W_LWB    = 13'b0_0_0_0_0_0_0_0_00_0_1_1;
    localparam logic [12:0] W_SWR    = 13'b0_0_0_0_0_1_1_1_00_0_0_0;
    localparam logic [12:0] W_BEQ    = 13'b0_1_1_0_0_0_0_0_01_0_0_0;
    localparam logic [12:0] W_QUIET  = 13'b0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [OP_W-1:0] opcode = '0;
    logic pc_wr, pc_wr_cond, pc_src, ir_wr, mem_rd, mem_wr;
    logic ext_sign, alu_imm, reg_dst_rd, reg_wr, mem_to_reg;
    logic [1:0] alu_op;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_ctrl #(.OP_W(OP_W), .UPC_W(4)) u_useq_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .ir_wr(ir_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ext_sign(ext_sign), .alu_imm(alu_imm),
        .alu_op(alu_op), .reg_dst_rd(reg_dst_rd), .reg_wr(reg_wr), .mem_to_reg(mem_to_reg)
    );

    function automatic int seq_len(int op);
        case (op)
            0, 13, 43: return 4;
            35:        return 5;
            default:   return 3;
        endcase
    endfunction

    function automatic logic [12:0] exp_word(int op, int s);
        if (s == 0) return W_FETCH;
        if (s == 1) return W_DECODE;
        case (op)
            0:  return (s == 2) ? W_REXE : W_RWB;
            13: return (s == 2) ? W_OEXE : W_OWB;
            35: return (s == 2) ? W_ADDR : ((s == 3) ? W_LRD : W_LWB);
            43: return (s == 2) ? W_ADDR : W_SWR;
            4:  return W_BEQ;
            default: return W_QUIET;
        endcase
    endfunction

    function automatic string tag_of(int op, int s);
        if (s == 0) return "R2 R11";
        if (s == 1) return "R2";
        case (op)
            0:  return "R3 R4 R11";
            13: return "R3 R5 R11";
            35: return "R3 R6 R11";
            43: return "R3 R7 R11";
            4:  return "R3 R8 R11";
            63: return "R3 R10 R11";
            default: return "R9 R11";
        endcase
    endfunction

    task automatic check(input logic [12:0] exp, input string tag);
        logic [12:0] act;
        act = {pc_wr, pc_wr_cond, pc_src, ir_wr, mem_rd, mem_wr, ext_sign, alu_imm,
               alu_op, reg_dst_rd, reg_wr, mem_to_reg};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
        if ((mem_rd && mem_wr) || (pc_wr && pc_wr_cond)) begin
            n_fail++;
            $display("FAIL R13: got %b expected no conflicting strobes", act);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check(W_FETCH, "R1");
        rst_n = 1'b1;
        // full sweep: each opcode runs its whole sequence, foreign opcode outside decode
        for (int op = 0; op < 64; op++) begin
            for (int s = 0; s < seq_len(op); s++) begin
                opcode = (s == 1) ? OP_W'(op) : OP_W'(op * 7 + s * 13 + 5);
                #1 check(exp_word(op, s), tag_of(op, s));
                @(negedge clk);
            end
        end
        opcode = '0;
        #1 check(W_FETCH, "R9 R10 return");
        // R12: reset during a load read cycle
        @(negedge clk);
        opcode = OP_W'(35);
        @(negedge clk);
        @(negedge clk);
        #1 check(W_LRD, "R6");
        rst_n = 1'b0;
        #1 check(W_FETCH, "R12");
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(W_FETCH, "R12");
        @(negedge clk);
        #1 check(W_DECODE, "R12");
        @(negedge clk);
        #1 check(W_ADDR, "R12");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule